// File: doc/BRIEF.md
# Cubic-Sum Recurrence Engine

This block iterates a nonlinear recurrence. A signed value W starts from a seed supplied with the start pulse. Each step derives the next W from the previous one and eight stored coefficient pairs (a, b). For every pair index i the engine forms t = a(i)·W + b(i)·W. It cubes t, scales the cube by a(i), and adds the eight scaled cubes together in a balanced tree. The new value is that sum minus three times the previous W, saturated to 16 bits.

The arithmetic is time-multiplexed. One multiplier and one adder/subtractor are shared under a small controller, so every step takes the same fixed number of cycles. Every new W leaves the block with a single-cycle valid strobe. After the last step a completion flag rises. The coefficient pairs are loaded through a simple write port while the engine is idle.

Top module: `cubrec_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `w_valid` and `done` are 0 and the engine is idle. A reset during a run abandons the run, and no further `w_valid` pulse follows.
- R2: An accepted start produces exactly eight results W(1)..W(8). Each result is marked by a `w_valid` high for one cycle. W(k) is presented 57·k rising edges after the edge that sampled `start` (8 terms × 6 cycles, 7 tree additions, 1 cycle for 3·W, 1 cycle for the subtraction).
- R3: For each index i in 0..7, t = a(i)·W + b(i)·W, and the scaled term is a(i)·t³, computed as the product chain a(i)·((t·t)·t). preW is the sum of the eight scaled terms.
- R4: W(k) = preW − 3·W(k−1). The difference is computed in 32 bits and clipped to [−32768, 32767]. The clipped value is the W used by the next step.
- R5: Seed, coefficients and outputs are signed Q8.8 two's complement (256 = 1.0). Every product is the full 64-bit product shifted right arithmetically by 8 and truncated to 32 bits. Internal sums wrap at 32 bits.
- R6: `done` rises together with the `w_valid` of W(8). It holds until the next accepted start, and it is 0 on the cycle after that start is sampled.
- R7: A `start` pulse while a run is in progress has no effect on the values or timing of that run.
- R8: A write with `ld_we` high while idle stores `ld_a` and `ld_b` as pair number `ld_addr` (0..7), and the next run uses them. A write while a run is in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with `seed` (accepted only when idle) |
| seed | input | 16 | Initial value W(0), Q8.8 |
| ld_we | input | 1 | Coefficient write enable |
| ld_addr | input | 3 | Coefficient pair index |
| ld_a | input | 16 | Coefficient a(i), Q8.8 |
| ld_b | input | 16 | Coefficient b(i), Q8.8 |
| w_out | output | 16 | Latest W(k), Q8.8 |
| w_valid | output | 1 | One-cycle strobe for a new W(k) |
| done | output | 1 | Run complete, held until the next start |

## Verification
The assertions assume that `start` and `ld_we` are synchronous to `clk`, and that reset is the only way to abort a run. They also assume that coefficients are meant to stay frozen from the start edge to completion. The bench drives every input on falling edges and loads coefficients only between runs, except where it deliberately writes or restarts during a run to exercise R7 and R8. The bench uses three coefficient sets:
- all zeros, so the recurrence reduces to −3·W and reaches both clip limits;
- mixed signs;
- large magnitudes, to reach 32-bit wrap.

// File: rtl/cubrec_pkg.sv
package cubrec_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MUL_A,
    ST_MUL_B,
    ST_SUM_T,
    ST_SQUARE,
    ST_CUBE,
    ST_WEIGHT,
    ST_REDUCE,
    ST_TRIPLE,
    ST_SUBTRACT
  } eng_state_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

endpackage

// File: rtl/cubrec_mul.sv
module cubrec_mul #(
  parameter int AW   = 32,
  parameter int FRAC = 8
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [AW-1:0] b_i,
  output logic signed [AW-1:0] p_o
);
  localparam int PW = 2 * AW;

  logic signed [PW-1:0] full_prod;
  logic                 unused_prod_bits;

  assign full_prod = $signed({{AW{a_i[AW-1]}}, a_i}) * $signed({{AW{b_i[AW-1]}}, b_i});
  // arithmetic shift by FRAC, then keep AW bits
  assign p_o = full_prod[FRAC +: AW];
  assign unused_prod_bits = ^{full_prod[PW-1:FRAC+AW], full_prod[FRAC-1:0]};
endmodule

// File: rtl/cubrec_addsub.sv
module cubrec_addsub #(
  parameter int AW = 32
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [AW-1:0] b_i,
  input  cubrec_pkg::alu_op_e  op_i,
  output logic signed [AW-1:0] r_o
);
  always_comb begin
    if (op_i == cubrec_pkg::OP_SUB) r_o = a_i - b_i;
    else                            r_o = a_i + b_i;
  end
endmodule

// File: rtl/cubrec_coef_store.sv
module cubrec_coef_store #(
  parameter int NS = 8,
  parameter int SW = 16,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [SW-1:0] wa_i,
  input  logic [SW-1:0] wb_i,
  input  logic [IW-1:0] raddr_i,
  output logic [SW-1:0] ra_o,
  output logic [SW-1:0] rb_o
);
  logic [NS-1:0][SW-1:0] coef_a_q, coef_a_d;
  logic [NS-1:0][SW-1:0] coef_b_q, coef_b_d;
  logic                  wr_en;

  assign wr_en = we_i & ~lock_i;

  always_comb begin
    coef_a_d = coef_a_q;
    coef_b_d = coef_b_q;
    if (wr_en) begin
      coef_a_d[waddr_i] = wa_i;
      coef_b_d[waddr_i] = wb_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_a_q <= '0;
      coef_b_q <= '0;
    end else if (wr_en) begin
      coef_a_q <= coef_a_d;
      coef_b_q <= coef_b_d;
    end
  end

  assign ra_o = coef_a_q[raddr_i];
  assign rb_o = coef_b_q[raddr_i];

  // R8: contents are frozen for the whole time the engine holds the lock
  assert_frozen_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> ($stable(coef_a_q) && $stable(coef_b_q)));
endmodule

// File: rtl/cubrec_term_file.sv
module cubrec_term_file #(
  parameter int NT = 8,
  parameter int AW = 32,
  localparam int IW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [IW-1:0] raddr0_i,
  input  logic [IW-1:0] raddr1_i,
  output logic [AW-1:0] rdata0_o,
  output logic [AW-1:0] rdata1_o
);
  logic [NT-1:0][AW-1:0] slot_q;

  for (genvar g = 0; g < NT; g++) begin : g_slot
    logic hit;
    assign hit = we_i && (waddr_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= wdata_i;
    end
  end

  assign rdata0_o = slot_q[raddr0_i];
  assign rdata1_o = slot_q[raddr1_i];
endmodule

// File: rtl/cubrec_engine.sv
module cubrec_engine #(
  parameter int SW   = 16,
  parameter int AW   = 32,
  parameter int FRAC = 8,
  parameter int NS   = 8,
  parameter int NIT  = 8,
  localparam int IW  = $clog2(NS),
  localparam int ITW = (NIT > 1) ? $clog2(NIT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] seed,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_addr,
  input  logic [SW-1:0] ld_a,
  input  logic [SW-1:0] ld_b,
  output logic [SW-1:0] w_out,
  output logic          w_valid,
  output logic          done
);
  import cubrec_pkg::*;

  localparam logic signed [AW-1:0] SAT_HI = AW'((2 ** (SW - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = -AW'(2 ** (SW - 1));

  eng_state_e       state_q, state_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [ITW-1:0]   iter_q, iter_d;
  logic [IW-1:0]    red_n_q, red_n_d;
  logic [IW-1:0]    red_j_q, red_j_d;
  logic [SW-1:0]    w_q, w_d;
  logic [AW-1:0]    acc_q, acc_d;
  logic [AW-1:0]    prod_q, prod_d;
  logic [AW-1:0]    t_q, t_d;
  logic [SW-1:0]    w_out_q, w_out_d;
  logic             w_valid_q, w_valid_d;
  logic             done_q, done_d;

  // shared datapath wiring
  logic [SW-1:0]    coef_a, coef_b;
  logic [AW-1:0]    coef_a_ext, coef_b_ext, w_ext;
  logic [AW-1:0]    mul_a, mul_b, mul_p;
  logic [AW-1:0]    alu_a, alu_b, alu_r;
  alu_op_e          alu_op;
  logic             tf_we;
  logic [IW-1:0]    tf_waddr, tf_raddr0, tf_raddr1;
  logic [AW-1:0]    tf_wdata, tf_rdata0, tf_rdata1;
  logic             engine_busy;
  logic             start_ok;
  logic [SW-1:0]    w_sat;

  assign engine_busy = (state_q != ST_IDLE);
  assign start_ok    = start && !engine_busy;

  assign coef_a_ext = {{(AW-SW){coef_a[SW-1]}}, coef_a};
  assign coef_b_ext = {{(AW-SW){coef_b[SW-1]}}, coef_b};
  assign w_ext      = {{(AW-SW){w_q[SW-1]}}, w_q};

  cubrec_coef_store #(.NS(NS), .SW(SW)) u_coef (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_i  (engine_busy),
    .we_i    (ld_we),
    .waddr_i (ld_addr),
    .wa_i    (ld_a),
    .wb_i    (ld_b),
    .raddr_i (idx_q),
    .ra_o    (coef_a),
    .rb_o    (coef_b)
  );

  cubrec_term_file #(.NT(NS), .AW(AW)) u_terms (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (tf_we),
    .waddr_i  (tf_waddr),
    .wdata_i  (tf_wdata),
    .raddr0_i (tf_raddr0),
    .raddr1_i (tf_raddr1),
    .rdata0_o (tf_rdata0),
    .rdata1_o (tf_rdata1)
  );

  cubrec_mul #(.AW(AW), .FRAC(FRAC)) u_mul (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (mul_p)
  );

  cubrec_addsub #(.AW(AW)) u_alu (
    .a_i  (alu_a),
    .b_i  (alu_b),
    .op_i (alu_op),
    .r_o  (alu_r)
  );

  // operand steering for the shared units
  always_comb begin
    mul_a     = coef_a_ext;
    mul_b     = w_ext;
    alu_a     = acc_q;
    alu_b     = prod_q;
    alu_op    = OP_ADD;
    tf_raddr0 = {red_j_q[IW-2:0], 1'b0};
    tf_raddr1 = {red_j_q[IW-2:0], 1'b1};
    unique case (state_q)
      ST_MUL_B:  begin mul_a = coef_b_ext; mul_b = w_ext;      end
      ST_SQUARE: begin mul_a = t_q;        mul_b = t_q;        end
      ST_CUBE:   begin mul_a = prod_q;     mul_b = t_q;        end
      ST_WEIGHT: begin mul_a = prod_q;     mul_b = coef_a_ext; end
      ST_REDUCE: begin alu_a = tf_rdata0;  alu_b = tf_rdata1;  end
      ST_TRIPLE: begin alu_a = w_ext << 1; alu_b = w_ext;      end
      ST_SUBTRACT: begin
        tf_raddr0 = '0;
        alu_a     = tf_rdata0;
        alu_b     = acc_q;
        alu_op    = OP_SUB;
      end
      default: ;
    endcase
  end

  // clip the 32-bit difference to the output range
  always_comb begin
    if ($signed(alu_r) > SAT_HI)      w_sat = SAT_HI[SW-1:0];
    else if ($signed(alu_r) < SAT_LO) w_sat = SAT_LO[SW-1:0];
    else                              w_sat = alu_r[SW-1:0];
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    iter_d    = iter_q;
    red_n_d   = red_n_q;
    red_j_d   = red_j_q;
    w_d       = w_q;
    acc_d     = acc_q;
    prod_d    = prod_q;
    t_d       = t_q;
    w_out_d   = w_out_q;
    w_valid_d = 1'b0;
    done_d    = done_q;
    tf_we     = 1'b0;
    tf_waddr  = idx_q;
    tf_wdata  = mul_p;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          w_d     = seed;
          idx_d   = '0;
          iter_d  = '0;
          done_d  = 1'b0;
          state_d = ST_MUL_A;
        end
      end
      ST_MUL_A: begin
        acc_d   = mul_p;
        state_d = ST_MUL_B;
      end
      ST_MUL_B: begin
        prod_d  = mul_p;
        state_d = ST_SUM_T;
      end
      ST_SUM_T: begin
        t_d     = alu_r;
        state_d = ST_SQUARE;
      end
      ST_SQUARE: begin
        prod_d  = mul_p;
        state_d = ST_CUBE;
      end
      ST_CUBE: begin
        prod_d  = mul_p;
        state_d = ST_WEIGHT;
      end
      ST_WEIGHT: begin
        tf_we = 1'b1;
        if (idx_q == IW'(NS - 1)) begin
          red_n_d = IW'(NS / 2);
          red_j_d = '0;
          state_d = ST_REDUCE;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_MUL_A;
        end
      end
      ST_REDUCE: begin
        tf_we    = 1'b1;
        tf_waddr = red_j_q;
        tf_wdata = alu_r;
        if (red_j_q == red_n_q - 1'b1) begin
          red_j_d = '0;
          if (red_n_q == IW'(1)) state_d = ST_TRIPLE;
          else                   red_n_d = red_n_q >> 1;
        end else begin
          red_j_d = red_j_q + 1'b1;
        end
      end
      ST_TRIPLE: begin
        acc_d   = alu_r;
        state_d = ST_SUBTRACT;
      end
      ST_SUBTRACT: begin
        w_d       = w_sat;
        w_out_d   = w_sat;
        w_valid_d = 1'b1;
        idx_d     = '0;
        if (iter_q == ITW'(NIT - 1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          iter_d  = iter_q + 1'b1;
          state_d = ST_MUL_A;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      iter_q    <= '0;
      red_n_q   <= '0;
      red_j_q   <= '0;
      w_q       <= '0;
      acc_q     <= '0;
      prod_q    <= '0;
      t_q       <= '0;
      w_out_q   <= '0;
      w_valid_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      iter_q    <= iter_d;
      red_n_q   <= red_n_d;
      red_j_q   <= red_j_d;
      w_q       <= w_d;
      acc_q     <= acc_d;
      prod_q    <= prod_d;
      t_q       <= t_d;
      w_out_q   <= w_out_d;
      w_valid_q <= w_valid_d;
      done_q    <= done_d;
    end
  end

  assign w_out   = w_out_q;
  assign w_valid = w_valid_q;
  assign done    = done_q;

  // R2: each result strobe lasts exactly one cycle
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |=> !w_valid);

  // R6: completion only ever appears together with a result strobe
  assert_done_with_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> w_valid);

  // R7: a start seen mid-run does not bring the engine back to idle
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && engine_busy && state_q != ST_SUBTRACT) |=> engine_busy);

  // R3: the tree reduction never reads past the live half of the term file
  assert_tree_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REDUCE) |-> (red_j_q < red_n_q));
endmodule

// File: tb/cubrec_engine_tb.sv
`timescale 1ns/1ps
module cubrec_engine_tb_top;
  localparam int LAT   = 6 * 8 + 7 + 2;
  localparam int WDOG  = 150000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] seed;
  logic        ld_we;
  logic [2:0]  ld_addr;
  logic [15:0] ld_a;
  logic [15:0] ld_b;
  logic [15:0] w_out;
  logic        w_valid;
  logic        done;

  cubrec_engine dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .seed    (seed),
    .ld_we   (ld_we),
    .ld_addr (ld_addr),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .w_out   (w_out),
    .w_valid (w_valid),
    .done    (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int model_a [8];
  int model_b [8];

  int exp_val [$];
  int exp_cyc [$];
  int exp_k   [$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int qmul(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return int'(p >>> 8);
  endfunction

  function automatic int clip16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int next_w(input int w);
    int s;
    int t;
    int term;
    s = 0;
    for (int i = 0; i < 8; i++) begin
      t    = qmul(model_a[i], w) + qmul(model_b[i], w);
      term = qmul(qmul(qmul(t, t), t), model_a[i]);
      s    = s + term;
    end
    return clip16(s - (w * 2 + w));
  endfunction

  task automatic load_pair(input int idx, input int a, input int b, input bit track);
    @(negedge clk);
    ld_we   = 1'b1;
    ld_addr = 3'(idx);
    ld_a    = 16'(a);
    ld_b    = 16'(b);
    @(negedge clk);
    ld_we = 1'b0;
    if (track) begin
      model_a[idx] = a;
      model_b[idx] = b;
    end
  endtask

  // driver: start a run and push the eight expected results
  task automatic launch(input int s);
    int w;
    int base;
    @(negedge clk);
    start = 1'b1;
    seed  = 16'(s);
    base  = cyc + 1;
    w     = s;
    for (int k = 1; k <= 8; k++) begin
      w = next_w(w);
      exp_val.push_back(w);
      exp_cyc.push_back(base + LAT * k);
      exp_k.push_back(k);
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R6 done cleared by start", int'(done), 0);
  endtask

  task automatic wait_drain();
    while (exp_val.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && w_valid) begin
      if (exp_val.size() == 0) begin
        check(1'b0, "R2 unexpected strobe", int'($signed(w_out)), 0);
      end else begin
        int ev, ec, ek;
        ev = exp_val.pop_front();
        ec = exp_cyc.pop_front();
        ek = exp_k.pop_front();
        check(int'($signed(w_out)) == ev, "R3/R4/R5 value", int'($signed(w_out)), ev);
        check(cyc == ec, "R2 timing", cyc, ec);
        check(done == (ek == 8), "R6 done with W(8)", int'(done), int'(ek == 8));
      end
    end
  end

  initial begin
    int sa [8] = '{64, -32, 128, 16, -80, 96, 48, -16};
    int sb [8] = '{32, 64, -64, 8, 40, -48, 24, 100};
    rst_n = 1'b0; start = 1'b0; seed = '0;
    ld_we = 1'b0; ld_addr = '0; ld_a = '0; ld_b = '0;
    for (int i = 0; i < 8; i++) begin model_a[i] = 0; model_b[i] = 0; end
    repeat (3) @(negedge clk);
    check(w_valid == 1'b0, "R1 valid in reset", int'(w_valid), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(w_valid == 1'b0 && done == 1'b0, "R1 after release", int'({w_valid, done}), 0);

    // R4: zero coefficients give W(k) = -3 W(k-1), reaching both clip limits
    launch(256);
    wait_drain();
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R6 done holds", int'(done), 1);

    // R3/R5: mixed-sign coefficients
    for (int i = 0; i < 8; i++) load_pair(i, sa[i], sb[i], 1'b1);
    launch(128);
    wait_drain();
    launch(-192);
    wait_drain();

    // R7: a second start during a run changes nothing
    // R8: writes during a run are dropped
    launch(300);
    repeat (100) @(negedge clk);
    start = 1'b1; seed = 16'(-1000);
    @(negedge clk);
    start = 1'b0;
    load_pair(3, 1000, -1000, 1'b0);
    load_pair(0, -500, 700, 1'b0);
    wait_drain();
    launch(77);
    wait_drain();

    // R8: idle write to the last pair takes effect; large values drive wrap
    load_pair(7, 2000, -1500, 1'b1);
    load_pair(2, -900, 1200, 1'b1);
    launch(-40);
    wait_drain();

    // R1: reset mid-run abandons the run
    launch(256);
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    exp_val.delete(); exp_cyc.delete(); exp_k.delete();
    @(negedge clk);
    check(w_valid == 1'b0 && done == 1'b0, "R1 reset mid-run", int'({w_valid, done}), 0);
    rst_n = 1'b1;
    repeat (LAT * 9) @(negedge clk);
    check(done == 1'b0, "R1 no completion after abort", int'(done), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule